// File: doc/BRIEF.md
# Interrupt Priority Grouping Mask Unit

This block holds the binary-point settings that divide an interrupt priority into a group-priority field and a subpriority field. For a requested interrupt group it drives a mask. The mask keeps the group-priority bits of a priority value and clears the subpriority bits, so that preemption logic elsewhere can compare only the group part. The unit holds three physical settings (group 0, secure group 1 and non-secure group 1) and two virtual settings (virtual group 0 and virtual group 1).

Non-secure group 1 and virtual group 1 use an offset rule: the stored value is one above the value the group 0 rule would need for the same split, and it can never be zero. Three common-binary-point controls make a group 1 lookup use the group 0 setting and the group 0 rule instead: one for secure group 1, one for non-secure group 1 and one for virtual group 1. Software writes pass through a single write port. Each write keeps only the low bits of the data and raises any value below the register's minimum to that minimum.

Top module: `prio_group_mask`

## Requirements
- R1: After reset, physical group 0 and secure group 1 hold MIN_BP, physical non-secure group 1 holds MIN_BP+1, virtual group 0 holds MIN_VBP and virtual group 1 holds MIN_VBP+1.
- R2: A group 0 lookup with setting N gives mask = (0xFF << (N+1)) truncated to 8 bits: 0 gives 0xFE, and 7 gives 0x00. Bit 0 of a physical group 0 mask is always 0.
- R3: A non-secure group 1 lookup with common mode off and setting N gives (0xFF << N) truncated: 1 gives 0xFE, and 7 gives 0x80. The mask MSB is always 1.
- R4: A secure group 1 lookup with secure common mode off uses the secure group 1 setting with the group 0 rule.
- R5: With cbpr_s_i set, a secure group 1 lookup returns the physical group 0 mask. With cbpr_ns_i set, a non-secure group 1 lookup returns the physical group 0 mask. Each control affects only its own group.
- R6: A virtual lookup (req_virt_i=1) with group code 0 uses virtual group 0 and the group 0 rule. Any other group code selects virtual group 1 and the offset rule, unless vcbpr_i is set; then virtual group 0 and the group 0 rule are used.
- R7: A write keeps wr_data_i[2:0] and then raises it to the register's minimum: MIN_BP for group 0 and secure group 1, MIN_BP+1 for non-secure group 1, MIN_VBP for virtual group 0 and MIN_VBP+1 for virtual group 1.
- R8: A write changes only its target register. The change appears on mask_o after the clock edge that captures it and not before. Registers without a write hold their value.
- R9: Group codes: 0 = group 0, 1 = secure group 1, 2 = non-secure group 1, 3 = reserved. A physical write with code 3 changes nothing, and a physical lookup with code 3 gives 0x00.
- R10: mask_o is always a run of ones from the MSB down followed by zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_virt_i | input | 1 | Write targets the virtual bank |
| wr_grp_i | input | 2 | Group code of the write target |
| wr_data_i | input | PRIO_W | Write data; only the low bits are kept |
| cbpr_s_i | input | 1 | Secure group 1 uses the group 0 setting |
| cbpr_ns_i | input | 1 | Non-secure group 1 uses the group 0 setting |
| vcbpr_i | input | 1 | Virtual group 1 uses the virtual group 0 setting |
| req_virt_i | input | 1 | Lookup in the virtual bank |
| req_grp_i | input | 2 | Group code of the lookup |
| mask_o | output | PRIO_W | Group-priority mask |

## Verification
Some properties are checked by assertions on every cycle: the mask shape, the fixed MSB of the non-secure group 1 mask, the cleared LSB of the group 0 mask, the zero mask for the reserved code, the register floor, and each register holding its value when not written. The bench alone can show the exact mask values for every setting and every control combination. The bench also covers truncation of out-of-range write data before the clamp, the one-cycle write timing, and the fact that a write to the reserved code changes no register.

// File: rtl/prio_grp_pkg.sv
package prio_grp_pkg;
  typedef enum logic [1:0] {
    GRP_G0   = 2'd0,
    GRP_G1S  = 2'd1,
    GRP_G1NS = 2'd2,
    GRP_RSV  = 2'd3
  } grp_e;

  localparam int NUM_BP  = 5;
  localparam int REG_G0  = 0;
  localparam int REG_G1S = 1;
  localparam int REG_G1N = 2;
  localparam int REG_VG0 = 3;
  localparam int REG_VG1 = 4;

  // floor of each register; offset-rule registers sit one above
  function automatic int bp_floor(int idx, int min_p, int min_v);
    case (idx)
      REG_G0, REG_G1S: return min_p;
      REG_G1N:         return min_p + 1;
      REG_VG0:         return min_v;
      default:         return min_v + 1;
    endcase
  endfunction
endpackage

// File: rtl/bp_reg.sv
module bp_reg #(
  parameter int BP_W = 3,
  parameter int MIN  = 0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [BP_W-1:0] d_i,
  output logic [BP_W-1:0] q_o
);
  localparam logic [BP_W-1:0] MinV = BP_W'(MIN);

  logic [BP_W-1:0] clamped;
  assign clamped = (d_i < MinV) ? MinV : d_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= MinV;
    else if (we_i) q_o <= clamped;
  end

  // R7
  floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o >= MinV);
  // R7
  wr_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && d_i >= MinV) |=> q_o == $past(d_i));
  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/mask_gen.sv
module mask_gen
  import prio_grp_pkg::*;
#(
  parameter int PRIO_W = 8,
  parameter int BP_W   = 3
) (
  input  logic [NUM_BP-1:0][BP_W-1:0] bp_i,
  input  logic                        virt_i,
  input  grp_e                        grp_i,
  input  logic                        cbpr_s_i,
  input  logic                        cbpr_ns_i,
  input  logic                        vcbpr_i,
  output logic [PRIO_W-1:0]           mask_o
);
  logic [BP_W-1:0] bp_sel;
  logic            offs;
  logic            valid;
  logic [BP_W:0]   shamt;

  always_comb begin
    bp_sel = bp_i[REG_G0];
    offs   = 1'b0;
    valid  = 1'b1;
    if (virt_i) begin
      if (grp_i == GRP_G0 || vcbpr_i) bp_sel = bp_i[REG_VG0];
      else begin
        bp_sel = bp_i[REG_VG1];
        offs   = 1'b1;
      end
    end else begin
      unique case (grp_i)
        GRP_G0:   bp_sel = bp_i[REG_G0];
        GRP_G1S:  bp_sel = cbpr_s_i ? bp_i[REG_G0] : bp_i[REG_G1S];
        GRP_G1NS: begin
          bp_sel = cbpr_ns_i ? bp_i[REG_G0] : bp_i[REG_G1N];
          offs   = !cbpr_ns_i;
        end
        default:  valid = 1'b0;
      endcase
    end
  end

  // offset registers are floored at >=1, so no underflow
  assign shamt  = {1'b0, bp_sel} - {{BP_W{1'b0}}, offs} + 1'b1;
  assign mask_o = valid ? ({PRIO_W{1'b1}} << shamt) : '0;
endmodule

// File: rtl/prio_group_mask.sv
module prio_group_mask
  import prio_grp_pkg::*;
#(
  parameter int PRIO_W  = 8,
  parameter int MIN_BP  = 0,
  parameter int MIN_VBP = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_virt_i,
  input  logic [1:0]        wr_grp_i,
  input  logic [PRIO_W-1:0] wr_data_i,
  input  logic              cbpr_s_i,
  input  logic              cbpr_ns_i,
  input  logic              vcbpr_i,
  input  logic              req_virt_i,
  input  logic [1:0]        req_grp_i,
  output logic [PRIO_W-1:0] mask_o
);
  localparam int BP_W = $clog2(PRIO_W);

  logic [NUM_BP-1:0]           we;
  logic [NUM_BP-1:0][BP_W-1:0] bp_q;

  always_comb begin
    we = '0;
    if (wr_en_i) begin
      if (wr_virt_i) begin
        if (wr_grp_i == GRP_G0) we[REG_VG0] = 1'b1;
        else                    we[REG_VG1] = 1'b1;
      end else if (wr_grp_i != GRP_RSV) begin
        we[wr_grp_i] = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    bp_reg #(
      .BP_W(BP_W),
      .MIN (bp_floor(i, MIN_BP, MIN_VBP))
    ) u_reg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (we[i]),
      .d_i   (wr_data_i[BP_W-1:0]),
      .q_o   (bp_q[i])
    );
  end

  mask_gen #(
    .PRIO_W(PRIO_W),
    .BP_W  (BP_W)
  ) u_mask (
    .bp_i     (bp_q),
    .virt_i   (req_virt_i),
    .grp_i    (grp_e'(req_grp_i)),
    .cbpr_s_i (cbpr_s_i),
    .cbpr_ns_i(cbpr_ns_i),
    .vcbpr_i  (vcbpr_i),
    .mask_o   (mask_o)
  );

  logic [PRIO_W-1:0] inv_m, inv_p1;
  assign inv_m  = ~mask_o;
  assign inv_p1 = inv_m + PRIO_W'(1);

  // R10
  mask_contig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_m & inv_p1) == '0);
  // R3
  ns_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_virt_i && req_grp_i == GRP_G1NS && !cbpr_ns_i) |-> mask_o[PRIO_W-1]);
  // R2
  g0_lsb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_virt_i && req_grp_i == GRP_G0) |-> !mask_o[0]);
  // R9
  rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_virt_i && req_grp_i == GRP_RSV) |-> mask_o == '0);
endmodule

// File: tb/prio_group_mask_tb.sv
module prio_group_mask_tb;
  localparam int MIN_BP  = 2;
  localparam int MIN_VBP = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_virt = 1'b0;
  logic [1:0] wr_grp = '0;
  logic [7:0] wr_data = '0;
  logic       cbpr_s = 1'b0, cbpr_ns = 1'b0, vcbpr = 1'b0;
  logic       req_virt = 1'b0;
  logic [1:0] req_grp = '0;
  logic [7:0] mask;

  int n_run = 0, n_fail = 0;
  int r[5];
  bit done = 0;

  always #10 clk = ~clk;

  prio_group_mask #(.PRIO_W(8), .MIN_BP(MIN_BP), .MIN_VBP(MIN_VBP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_virt_i(wr_virt),
    .wr_grp_i(wr_grp), .wr_data_i(wr_data), .cbpr_s_i(cbpr_s),
    .cbpr_ns_i(cbpr_ns), .vcbpr_i(vcbpr), .req_virt_i(req_virt),
    .req_grp_i(req_grp), .mask_o(mask)
  );

  function automatic int model(int v, int g, int cs, int cns, int vc);
    int bp, off;
    off = 0;
    if (v != 0) begin
      if (g == 0 || vc != 0) bp = r[3];
      else begin bp = r[4]; off = 1; end
    end else begin
      case (g)
        0: bp = r[0];
        1: bp = (cs != 0) ? r[0] : r[1];
        2: if (cns != 0) bp = r[0]; else begin bp = r[2]; off = 1; end
        default: return 0;
      endcase
    end
    return (255 << (bp - off + 1)) & 255;
  endfunction

  function automatic int floor_of(int idx);
    case (idx)
      0, 1: return MIN_BP;
      2: return MIN_BP + 1;
      3: return MIN_VBP;
      default: return MIN_VBP + 1;
    endcase
  endfunction

  task automatic chk(string req, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: mask=%02h expected=%02h", req, got, exp);
    end
  endtask

  task automatic lookup(int v, int g, int cs, int cns, int vc);
    req_virt = v[0]; req_grp = g[1:0];
    cbpr_s = cs[0]; cbpr_ns = cns[0]; vcbpr = vc[0];
    #1;
  endtask

  task automatic sweep(string force_req);
    for (int v = 0; v < 2; v++)
      for (int g = 0; g < 4; g++)
        for (int c = 0; c < 8; c++) begin
          string req;
          bit contig;
          lookup(v, g, c & 1, (c >> 1) & 1, (c >> 2) & 1);
          if (force_req != "") req = force_req;
          else if (v == 1) req = "R6";
          else if (g == 3) req = "R9";
          else if ((g == 1 && (c & 1) != 0) || (g == 2 && (c & 2) != 0)) req = "R5";
          else if (g == 0) req = "R2";
          else if (g == 1) req = "R4";
          else req = "R3";
          chk(req, int'(mask), model(v, g, c & 1, (c >> 1) & 1, (c >> 2) & 1));
          contig = 0;
          for (int k = 0; k <= 8; k++)
            if (int'(mask) == ((255 << k) & 255)) contig = 1;
          chk("R10", int'(contig), 1);
        end
  endtask

  // lookup that exposes register idx directly
  task automatic target(int idx);
    case (idx)
      0: lookup(0, 0, 0, 0, 0);
      1: lookup(0, 1, 0, 0, 0);
      2: lookup(0, 2, 0, 0, 0);
      3: lookup(1, 0, 0, 0, 0);
      default: lookup(1, 1, 0, 0, 0);
    endcase
  endtask

  task automatic do_write(int v, int g, int d);
    int idx, val;
    idx = (v != 0) ? ((g == 0) ? 3 : 4) : ((g == 3) ? -1 : g);
    @(negedge clk);
    wr_en = 1'b1; wr_virt = v[0]; wr_grp = g[1:0]; wr_data = d[7:0];
    if (idx >= 0) begin
      target(idx);
      chk("R8", int'(mask), model(v, (v != 0 && g != 0) ? 1 : g, 0, 0, 0));
    end
    @(posedge clk);
    if (idx >= 0) begin
      val = d & 7;
      if (val < floor_of(idx)) val = floor_of(idx);
      r[idx] = val;
    end
    @(negedge clk);
    wr_en = 1'b0;
    if (idx >= 0) begin
      target(idx);
      chk("R7", int'(mask), model(v, (v != 0 && g != 0) ? 1 : g, 0, 0, 0));
    end
    sweep("");
  endtask

  initial begin
    for (int i = 0; i < 5; i++) r[i] = floor_of(i);
    #35 rst_n = 1'b1;
    @(negedge clk);
    sweep("R1");
    for (int d = 0; d < 16; d++) do_write(0, 0, d);
    for (int d = 0; d < 16; d++) do_write(0, 1, d);
    for (int d = 0; d < 16; d++) do_write(0, 2, d);
    for (int d = 0; d < 16; d++) do_write(1, 0, d);
    for (int d = 0; d < 16; d++) do_write(1, 2, d);
    do_write(1, 1, 5);
    do_write(1, 3, 200);
    do_write(0, 0, 0);
    do_write(0, 3, 7);
    do_write(0, 2, 255);
    do_write(0, 2, 8);
    do_write(0, 3, 1);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule